// File: doc/BRIEF.md
# Multi-Channel Memory Request Arbiter

This block sits at the front of a multi-port memory controller. Several requesting channels each run on a clock of their own. Every enabled channel pushes its requests into an asynchronous input FIFO that carries them into the controller clock domain. A round-robin arbiter picks one channel with pending work. A sequencer state machine then performs that request on the single memory port. The acknowledge and any read data travel back through a per-channel asynchronous output FIFO into the requester's clock domain.

The operation comes from a two-bit command field: 00 none, 01 load, 10 store, 11 read-modify-write. A read-modify-write reads a word and combines it byte by byte with the request data. It writes the result back with no other access in between and returns the old word. Per-byte swap or per-byte add is selected by a swap flag. Channels can be removed at elaboration through a presence mask.

The sequencer states are IDLE, READ, WRITE, RMW_RD, RMW_WR and REPLY. IDLE goes to READ, WRITE, RMW_RD or REPLY on a grant, depending on the command. READ and WRITE go to REPLY on the memory acknowledge. RMW_RD goes to RMW_WR on its acknowledge, and RMW_WR goes to REPLY on its own. REPLY pushes the response and returns to IDLE.

Top module: `mem_channel_arbiter`

## Requirements
- R1: After reset, mem_req and every ch_ack are low, and ch_req_ready is high exactly for the channels present in CH_MASK.
- R2: Each accepted request produces exactly one ch_ack pulse on its own channel, in that channel's clock domain, and requests of one channel complete in order.
- R3: A load (cmd 01) makes one memory read of the given address and returns the word read on ch_rdata.
- R4: A store (cmd 10) makes one memory write in which only the bytes with ch_req_be set (bit b covers data bits 8b+7..8b) change; its response data is zero.
- R5: A request with cmd 00 makes no memory access and is acknowledged with zero data.
- R6: A read-modify-write (cmd 11) with swap=0 writes back, in each byte enabled by be, the old byte plus the request byte modulo 256; it leaves other bytes unchanged and returns the old word.
- R7: A read-modify-write with swap=1 replaces each enabled byte with the request byte and returns the old word.
- R8: The write of a read-modify-write is the very next memory access after its read and targets the same address.
- R9: Once mem_req rises it stays high, with address and direction unchanged, until mem_ack; only one access is outstanding at a time.
- R10: With several channels pending, grants rotate in ascending channel order among present channels, starting after the last one served.
- R11: ch_req_ready falls when a channel's input FIFO is full, and a request is taken only when ready is high.
- R12: A channel absent from CH_MASK never asserts ready, never receives a grant and never acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ch_clk | input | NCH | Per-channel clocks |
| ch_req_valid | input | NCH | Request strobe per channel |
| ch_req_ready | output | NCH | Input FIFO has room |
| ch_req_cmd | input | 2*NCH | Command per channel (00 none, 01 load, 10 store, 11 RMW) |
| ch_req_swap | input | NCH | RMW kind: 1 swap, 0 add |
| ch_req_addr | input | ADDR_W*NCH | Word address per channel |
| ch_req_wdata | input | DATA_W*NCH | Write or operand data per channel |
| ch_req_be | input | DATA_W/8*NCH | Byte enables per channel |
| ch_ack | output | NCH | One-cycle completion pulse per channel |
| ch_rdata | output | DATA_W*NCH | Response data, valid with ch_ack |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory byte enables |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The bench builds the block with four channels and CH_MASK 4'b1011, so channel 2 is configured out. This lets the bench show that a missing channel stays silent and that rotation skips the gap from 1 to 3. The data path is 64 bits wide, so byte-enable patterns and per-byte wraparound in the add stay readable. Depth-4 input FIFOs let a stalled memory fill one channel's queue in a few requests and expose the ready backpressure. The four channel clocks have unrelated periods, so every crossing works under drifting phase.

// File: rtl/mca_pkg.sv
`timescale 1ns/1ps
package mca_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_LOAD  = 2'b01,
        CMD_STORE = 2'b10,
        CMD_RMW   = 2'b11
    } mcmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RMW_RD,
        ST_RMW_WR,
        ST_REPLY
    } seq_state_e;

endpackage

// File: rtl/mca_async_fifo.sv
`timescale 1ns/1ps
module mca_async_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_MASK = (AW+1)'(3) << (AW-1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW:0] wbin, wgray, rbin, rgray;
    logic [AW:0] wq1, wq2, rq1, rq2;
    logic [AW:0] wbin_nxt, rbin_nxt;
    logic        wr_go, rd_go;

    assign wr_go    = wr_en && !wr_full;
    assign rd_go    = rd_en && !rd_empty;
    assign wbin_nxt = wbin + (AW+1)'(wr_go);
    assign rbin_nxt = rbin + (AW+1)'(rd_go);

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            rq1   <= '0;
            rq2   <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= (wbin_nxt >> 1) ^ wbin_nxt;
            rq1   <= rgray;
            rq2   <= rq1;
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_go) store[wbin[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            wq1   <= '0;
            wq2   <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= (rbin_nxt >> 1) ^ rbin_nxt;
            wq1   <= wgray;
            wq2   <= wq1;
        end
    end

    assign wr_full  = (wgray == (rq2 ^ FULL_MASK));
    assign rd_empty = (rgray == wq2);
    assign rd_data  = store[rbin[AW-1:0]];
endmodule

// File: rtl/mca_rr_arbiter.sv
`timescale 1ns/1ps
module mca_rr_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any
);
    logic [IW-1:0] last_q;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int off = 1; off <= N; off++) begin
            automatic int c = (int'(last_q) + off) % N;
            if (!any && req[c]) begin
                any       = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = IW'(c);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_q <= IW'(N-1);
        else if (take) last_q <= grant_idx;
    end
endmodule

// File: rtl/mca_sequencer.sv
`timescale 1ns/1ps
module mca_sequencer import mca_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 256,
    parameter int IW     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arb_any,
    input  logic [IW-1:0]       arb_idx,
    output logic                arb_take,
    input  logic [1:0]          req_cmd,
    input  logic                req_swap,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                resp_push,
    output logic [IW-1:0]       resp_idx,
    output logic [DATA_W-1:0]   resp_data,
    output logic [1:0]          cur_cmd,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [DATA_W/8-1:0] mem_be,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int BE_W = DATA_W / 8;

    seq_state_e          state_q, state_d;
    mcmd_e               cmd_q;
    logic                swap_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q, rdat_q, merged;
    logic [BE_W-1:0]     be_q;
    logic [IW-1:0]       idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and read-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NONE;
            swap_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            idx_q   <= '0;
            rdat_q  <= '0;
        end else if (state_q == ST_IDLE && arb_any) begin
            cmd_q   <= mcmd_e'(req_cmd);
            swap_q  <= req_swap;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            idx_q   <= arb_idx;
            rdat_q  <= '0;
        end else if ((state_q == ST_READ || state_q == ST_RMW_RD) && mem_ack) begin
            rdat_q  <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arb_any) begin
                unique case (mcmd_e'(req_cmd))
                    CMD_LOAD:  state_d = ST_READ;
                    CMD_STORE: state_d = ST_WRITE;
                    CMD_RMW:   state_d = ST_RMW_RD;
                    default:   state_d = ST_REPLY;
                endcase
            end
            ST_READ:   if (mem_ack) state_d = ST_REPLY;
            ST_WRITE:  if (mem_ack) state_d = ST_REPLY;
            ST_RMW_RD: if (mem_ack) state_d = ST_RMW_WR;
            ST_RMW_WR: if (mem_ack) state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // byte-wise combine for read-modify-write
    always_comb begin
        for (int b = 0; b < BE_W; b++) begin
            if (!be_q[b])    merged[8*b +: 8] = rdat_q[8*b +: 8];
            else if (swap_q) merged[8*b +: 8] = wdata_q[8*b +: 8];
            else             merged[8*b +: 8] = rdat_q[8*b +: 8] + wdata_q[8*b +: 8];
        end
    end

    // outputs
    always_comb begin
        arb_take  = (state_q == ST_IDLE) && arb_any;
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE) ||
                    (state_q == ST_RMW_RD) || (state_q == ST_RMW_WR);
        mem_we    = (state_q == ST_WRITE) || (state_q == ST_RMW_WR);
        mem_addr  = addr_q;
        mem_wdata = (state_q == ST_RMW_WR) ? merged : wdata_q;
        mem_be    = (state_q == ST_RMW_WR) ? {BE_W{1'b1}} : be_q;
        resp_push = (state_q == ST_REPLY);
        resp_idx  = idx_q;
        resp_data = rdat_q;
        cur_cmd   = cmd_q;
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/mem_channel_arbiter.sv
`timescale 1ns/1ps
module mem_channel_arbiter #(
    parameter int             NCH       = 4,
    parameter int             ADDR_W    = 32,
    parameter int             DATA_W    = 256,
    parameter int             IN_DEPTH  = 4,
    parameter int             OUT_DEPTH = 4,
    parameter logic [NCH-1:0] CH_MASK   = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             ch_clk,
    input  logic [NCH-1:0]             ch_req_valid,
    output logic [NCH-1:0]             ch_req_ready,
    input  logic [2*NCH-1:0]           ch_req_cmd,
    input  logic [NCH-1:0]             ch_req_swap,
    input  logic [ADDR_W*NCH-1:0]      ch_req_addr,
    input  logic [DATA_W*NCH-1:0]      ch_req_wdata,
    input  logic [DATA_W/8*NCH-1:0]    ch_req_be,
    output logic [NCH-1:0]             ch_ack,
    output logic [DATA_W*NCH-1:0]      ch_rdata,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic [DATA_W/8-1:0]        mem_be,
    input  logic                       mem_ack,
    input  logic [DATA_W-1:0]          mem_rdata
);
    localparam int BE_W  = DATA_W / 8;
    localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int REQ_W = 2 + 1 + ADDR_W + DATA_W + BE_W;

    logic [REQ_W-1:0]  in_head [NCH];
    logic [NCH-1:0]    in_empty, out_full, pop_vec, push_vec, arb_req, grant;
    logic [IW-1:0]     arb_idx, resp_idx;
    logic              arb_any, arb_take, resp_push, seq_busy;
    logic [DATA_W-1:0] resp_data;
    logic [1:0]        cur_cmd;
    logic [REQ_W-1:0]  head;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (CH_MASK[i]) begin : g_on
            logic [REQ_W-1:0]  wr_word;
            logic              in_full, o_empty, ack_q;
            logic [DATA_W-1:0] o_head, rd_q;

            assign wr_word = {ch_req_cmd[2*i +: 2], ch_req_swap[i],
                              ch_req_addr[ADDR_W*i +: ADDR_W],
                              ch_req_wdata[DATA_W*i +: DATA_W],
                              ch_req_be[BE_W*i +: BE_W]};

            mca_async_fifo #(.WIDTH(REQ_W), .DEPTH(IN_DEPTH)) u_in (
                .wr_clk(ch_clk[i]), .wr_rst_n(rst_n), .wr_en(ch_req_valid[i]),
                .wr_data(wr_word), .wr_full(in_full),
                .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(pop_vec[i]),
                .rd_data(in_head[i]), .rd_empty(in_empty[i]));

            mca_async_fifo #(.WIDTH(DATA_W), .DEPTH(OUT_DEPTH)) u_out (
                .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(push_vec[i]),
                .wr_data(resp_data), .wr_full(out_full[i]),
                .rd_clk(ch_clk[i]), .rd_rst_n(rst_n), .rd_en(!o_empty),
                .rd_data(o_head), .rd_empty(o_empty));

            always_ff @(posedge ch_clk[i] or negedge rst_n) begin
                if (!rst_n) begin
                    ack_q <= 1'b0;
                    rd_q  <= '0;
                end else begin
                    ack_q <= !o_empty;
                    rd_q  <= o_empty ? '0 : o_head;
                end
            end

            assign ch_req_ready[i]            = !in_full;
            assign ch_ack[i]                  = ack_q;
            assign ch_rdata[DATA_W*i +: DATA_W] = rd_q;
        end else begin : g_off
            assign in_head[i]                 = '0;
            assign in_empty[i]                = 1'b1;
            assign out_full[i]                = 1'b1;
            assign ch_req_ready[i]            = 1'b0;
            assign ch_ack[i]                  = 1'b0;
            assign ch_rdata[DATA_W*i +: DATA_W] = '0;
        end
    end

    assign arb_req = ~in_empty & ~out_full & CH_MASK;

    mca_rr_arbiter #(.N(NCH), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(arb_req), .take(arb_take),
        .grant(grant), .grant_idx(arb_idx), .any(arb_any));

    assign head    = in_head[arb_idx];
    assign pop_vec = arb_take ? grant : '0;

    always_comb begin
        for (int i = 0; i < NCH; i++) push_vec[i] = resp_push && (int'(resp_idx) == i);
    end

    mca_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .arb_any(arb_any), .arb_idx(arb_idx), .arb_take(arb_take),
        .req_cmd(head[REQ_W-1 -: 2]),
        .req_swap(head[BE_W+DATA_W+ADDR_W]),
        .req_addr(head[BE_W+DATA_W +: ADDR_W]),
        .req_wdata(head[BE_W +: DATA_W]),
        .req_be(head[BE_W-1:0]),
        .resp_push(resp_push), .resp_idx(resp_idx), .resp_data(resp_data),
        .cur_cmd(cur_cmd), .busy(seq_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata));
endmodule

// File: rtl/mca_checker.sv
`timescale 1ns/1ps
module mca_checker #(
    parameter int             NCH     = 4,
    parameter int             ADDR_W  = 32,
    parameter logic [NCH-1:0] CH_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NCH-1:0]    grant,
    input logic [NCH-1:0]    arb_req,
    input logic [NCH-1:0]    push_vec,
    input logic [NCH-1:0]    out_full,
    input logic [1:0]        cur_cmd,
    input logic              busy
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~arb_req) == '0));

    assert_atomic_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && cur_cmd == 2'b11)
            |=> (mem_req && mem_we && mem_addr == $past(mem_addr)));

    assert_resp_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vec & out_full) == '0);

    assert_none_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_cmd == 2'b00) |-> !mem_req);

    assert_absent_channel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant | push_vec) & ~CH_MASK) == '0);
endmodule

bind mem_channel_arbiter mca_checker #(
    .NCH(NCH), .ADDR_W(ADDR_W), .CH_MASK(CH_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .grant(grant),
    .arb_req(arb_req), .push_vec(push_vec), .out_full(out_full),
    .cur_cmd(cur_cmd), .busy(seq_busy)
);

// File: tb/mem_channel_arbiter_test.sv
`timescale 1ns/1ps
module mem_channel_arbiter_test;
    localparam int NCH = 4, AW = 8, DW = 64, BW = 8, SL = 32;
    localparam logic [NCH-1:0] MASK = 4'b1011;

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  cmd;
        logic        swap;
        logic [5:0]  addr;
        logic [63:0] wdata;
        logic [7:0]  be;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'b10, 1'b0, 6'd5,  64'h1122334455667788, 8'hFF},
        '{2'd1, 2'b01, 1'b0, 6'd5,  64'h0,                8'h00},
        '{2'd3, 2'b10, 1'b0, 6'd5,  64'hA0A1A2A3A4A5A6A7, 8'h0F},
        '{2'd0, 2'b01, 1'b0, 6'd5,  64'h0,                8'hFF},
        '{2'd1, 2'b11, 1'b0, 6'd5,  64'h0101010101010101, 8'hF0},
        '{2'd3, 2'b01, 1'b0, 6'd5,  64'h0,                8'h00},
        '{2'd0, 2'b11, 1'b1, 6'd9,  64'hDEADBEEFCAFEF00D, 8'h3C},
        '{2'd1, 2'b01, 1'b0, 6'd9,  64'h0,                8'h00},
        '{2'd3, 2'b11, 1'b0, 6'd12, 64'hFFFFFFFFFFFFFFFF, 8'hFF},
        '{2'd0, 2'b01, 1'b0, 6'd12, 64'h0,                8'h00},
        '{2'd1, 2'b00, 1'b0, 6'd7,  64'h5555555555555555, 8'hFF},
        '{2'd3, 2'b10, 1'b0, 6'd7,  64'h7777777777777777, 8'h00},
        '{2'd0, 2'b01, 1'b0, 6'd7,  64'h0,                8'h00}
    };

    logic clk = 0, rst_n = 0, stall = 0;
    logic ck0 = 0, ck1 = 0, ck2 = 0, ck3 = 0;
    logic [NCH-1:0]    ch_clk, ch_req_valid, ch_req_ready, ch_req_swap, ch_ack;
    logic [2*NCH-1:0]  ch_req_cmd;
    logic [AW*NCH-1:0] ch_req_addr;
    logic [DW*NCH-1:0] ch_req_wdata, ch_rdata;
    logic [BW*NCH-1:0] ch_req_be;
    logic              mem_req, mem_we, mem_ack;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata, mem_rdata;
    logic [BW-1:0]     mem_be;

    always #2 clk = ~clk;
    always #3 ck0 = ~ck0;
    always #5 ck1 = ~ck1;
    always #4 ck2 = ~ck2;
    always #7 ck3 = ~ck3;
    assign ch_clk = {ck3, ck2, ck1, ck0};

    mem_channel_arbiter #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW),
        .IN_DEPTH(4), .OUT_DEPTH(4), .CH_MASK(MASK)) uut (.*);

    // posting mailboxes filled by the main sequence
    int          posted [NCH];
    logic [1:0]  s_cmd   [NCH][SL];
    logic        s_swap  [NCH][SL];
    logic [5:0]  s_addr  [NCH][SL];
    logic [63:0] s_wdata [NCH][SL];
    logic [7:0]  s_be    [NCH][SL];
    int          sent_a [NCH];
    int          rcnt_a [NCH];
    logic [63:0] last_a [NCH];

    for (genvar g = 0; g < NCH; g++) begin : drv
        logic        v_l = 0, fire = 0, sw_l = 0;
        logic [1:0]  c_l = 0;
        logic [AW-1:0] a_l = 0;
        logic [63:0] d_l = 0, last_l = 0;
        logic [7:0]  b_l = 0;
        int          sent_l = 0, rcnt_l = 0;
        always @(negedge ch_clk[g]) begin
            if (fire) sent_l = sent_l + 1;
            if (sent_l < posted[g]) begin
                v_l = 1; c_l = s_cmd[g][sent_l]; sw_l = s_swap[g][sent_l];
                a_l = {2'b00, s_addr[g][sent_l]}; d_l = s_wdata[g][sent_l]; b_l = s_be[g][sent_l];
            end else v_l = 0;
            fire = v_l && ch_req_ready[g];
            if (ch_ack[g]) begin
                last_l = ch_rdata[DW*g +: DW];
                rcnt_l = rcnt_l + 1;
            end
        end
        assign ch_req_valid[g]          = v_l;
        assign ch_req_cmd[2*g +: 2]     = c_l;
        assign ch_req_swap[g]           = sw_l;
        assign ch_req_addr[AW*g +: AW]  = a_l;
        assign ch_req_wdata[DW*g +: DW] = d_l;
        assign ch_req_be[BW*g +: BW]    = b_l;
        assign sent_a[g] = sent_l;
        assign rcnt_a[g] = rcnt_l;
        assign last_a[g] = last_l;
    end

    // memory model
    logic [63:0] marr [64];
    logic [63:0] sh   [64];
    int          mcount = 0;
    logic [AW-1:0] log_addr [1024];
    logic          log_we   [1024];
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 0;
        else if (mem_req && !mem_ack && !stall) begin
            mem_ack   <= 1;
            mem_rdata <= marr[mem_addr[5:0]];
            if (mem_we)
                for (int b = 0; b < BW; b++)
                    if (mem_be[b]) marr[mem_addr[5:0]][8*b +: 8] = mem_wdata[8*b +: 8];
            log_addr[mcount] = mem_addr;
            log_we[mcount]   = mem_we;
            mcount = mcount + 1;
        end else mem_ack <= 0;
    end

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic post(input int ch, input logic [1:0] cmd, input logic sw,
                        input logic [5:0] a, input logic [63:0] d, input logic [7:0] be);
        s_cmd[ch][posted[ch]] = cmd; s_swap[ch][posted[ch]] = sw; s_addr[ch][posted[ch]] = a;
        s_wdata[ch][posted[ch]] = d; s_be[ch][posted[ch]] = be;
        posted[ch] = posted[ch] + 1;
    endtask

    task automatic wait_ack(input int ch, input int target, input string req);
        int t = 0;
        while (rcnt_a[ch] < target && t < 4000) begin @(posedge clk); t++; end
        if (rcnt_a[ch] < target) check(0, req, 64'(rcnt_a[ch]), 64'(target));
        repeat (2) @(posedge clk);
        #1;
    endtask

    function automatic int next_en(input int c);
        int n = c;
        for (int k = 0; k < NCH; k++) begin
            n = (n + 1) % NCH;
            if (MASK[n]) return n;
        end
        return c;
    endfunction

    initial begin
        for (int i = 0; i < NCH; i++) posted[i] = 0;
        for (int i = 0; i < 64; i++) begin
            marr[i] = 64'h0101010101010101 * 64'(i);
            sh[i]   = marr[i];
        end
        repeat (6) @(posedge clk);
        #1;
        // R1: reset state
        check(mem_req == 0, "R1 mem_req", 64'(mem_req), 0);
        check(ch_ack == 0, "R1 ch_ack", 64'(ch_ack), 0);
        rst_n = 1;
        repeat (4) @(posedge clk);
        #1;
        check(ch_req_ready == MASK, "R1 ready", 64'(ch_req_ready), 64'(MASK));

        // vector table
        for (int k = 0; k < NV; k++) begin
            automatic vec_t v = VEC[k];
            automatic int ch = int'(v.ch);
            automatic int base = mcount;
            automatic int n = rcnt_a[ch];
            automatic logic [63:0] old = sh[v.addr];
            automatic logic [63:0] exp;
            automatic int nacc;
            post(ch, v.cmd, v.swap, v.addr, v.wdata, v.be);
            wait_ack(ch, n + 1, "R2 ack arrival");
            case (v.cmd)
                2'b01: begin exp = old; nacc = 1; end                          // R3
                2'b10: begin exp = 0; nacc = 1;                                // R4
                    for (int b = 0; b < 8; b++) if (v.be[b]) sh[v.addr][8*b +: 8] = v.wdata[8*b +: 8];
                end
                2'b11: begin exp = old; nacc = 2;                              // R6 R7
                    for (int b = 0; b < 8; b++) if (v.be[b])
                        sh[v.addr][8*b +: 8] = v.swap ? v.wdata[8*b +: 8] : old[8*b +: 8] + v.wdata[8*b +: 8];
                end
                default: begin exp = 0; nacc = 0; end                          // R5
            endcase
            check(last_a[ch] == exp, v.cmd == 2'b11 ? (v.swap ? "R7 old value" : "R6 old value") :
                  v.cmd == 2'b00 ? "R5 zero reply" : v.cmd == 2'b10 ? "R4 zero reply" : "R3 load data",
                  last_a[ch], exp);
            check(mcount - base == nacc, v.cmd == 2'b00 ? "R5 access count" : "R9 access count",
                  64'(mcount - base), 64'(nacc));
            check(marr[v.addr] == sh[v.addr], v.cmd == 2'b11 ? "R6 R7 memory" : "R4 memory",
                  marr[v.addr], sh[v.addr]);
            if (v.cmd == 2'b11 && mcount - base == 2)
                check(!log_we[base] && log_we[base+1] && log_addr[base] == log_addr[base+1],
                      "R8 read then write", {55'd0, log_we[base+1], log_addr[base+1]}, {55'd0, 1'b1, 2'b0, v.addr});
        end

        // R10: round-robin rotation under a stalled memory
        begin
            automatic int mark = mcount;
            stall = 1;
            for (int k = 0; k < 2; k++) begin
                post(0, 2'b01, 0, 6'(32 + 0 + k), 0, 0);
                post(1, 2'b01, 0, 6'(32 + 2 + k), 0, 0);
                post(3, 2'b01, 0, 6'(32 + 6 + k), 0, 0);
            end
            repeat (300) @(posedge clk);
            #1;
            stall = 0;
            wait_ack(0, rcnt_a[0] + 2 - (rcnt_a[0] % 1), "R2 rotation acks");
            wait_ack(3, posted[3], "R2 rotation acks");
            wait_ack(1, posted[1], "R2 rotation acks");
            wait_ack(0, posted[0], "R2 rotation acks");
            for (int k = 1; k < 6; k++) begin
                automatic int pc = (int'(log_addr[mark+k-1]) - 32) >> 1;
                automatic int cc = (int'(log_addr[mark+k]) - 32) >> 1;
                check(cc == next_en(pc), "R10 rotation", 64'(cc), 64'(next_en(pc)));
            end
        end

        // R11: backpressure on one channel
        begin
            automatic int r0 = rcnt_a[1];
            stall = 1;
            for (int k = 0; k < 7; k++) post(1, 2'b01, 0, 6'(48 + k), 0, 0);
            repeat (300) @(posedge clk);
            #1;
            check(ch_req_ready[1] == 0, "R11 ready low", 64'(ch_req_ready[1]), 0);
            check(sent_a[1] == posted[1] - 2, "R11 accepted count", 64'(sent_a[1]), 64'(posted[1] - 2));
            stall = 0;
            wait_ack(1, r0 + 7, "R11 drain");
            check(last_a[1] == sh[54], "R2 in-order last data", last_a[1], sh[54]);
            check(rcnt_a[1] == r0 + 7, "R2 ack count", 64'(rcnt_a[1]), 64'(r0 + 7));
        end

        // R12: configured-out channel
        begin
            automatic int base = mcount;
            post(2, 2'b01, 0, 6'd3, 0, 0);
            repeat (200) @(posedge clk);
            #1;
            check(ch_req_ready[2] == 0, "R12 ready", 64'(ch_req_ready[2]), 0);
            check(mcount == base, "R12 no access", 64'(mcount), 64'(base));
            check(rcnt_a[2] == 0, "R12 no ack", 64'(rcnt_a[2]), 0);
        end

        // R2: one acknowledge per request on every present channel
        for (int c = 0; c < NCH; c++)
            if (MASK[c]) check(rcnt_a[c] == posted[c], "R2 one ack each", 64'(rcnt_a[c]), 64'(posted[c]));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule